// File: doc/BRIEF.md
# Serial line status register

This block is the CPU-visible line status byte of a FIFO-based serial controller. It collects four receive error conditions (overrun, parity, framing, break), a receive FIFO interrupt request, a transmit FIFO level indication and a transmitter idle indication into one byte. Receiver error events arrive as single-cycle pulses and are held as sticky flags. FIFO fill levels, programmed thresholds and the transmit state machine idle signal arrive as plain inputs.

The error flags and the receive request are one storage, seen through two views. The line status view is `lsr_o`. The receive status view is `rx_stat_o`. A CPU read strobe on the line status register returns the current byte and clears the error flags in both views from the next cycle. The receive request follows the receive FIFO level, and the CPU can acknowledge it by writing a zero to bit 0. It is masked for as long as the receive FIFO is being read.

Top module: `line_stat_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `lsr_o` and `rx_stat_o` are both 8'h00.
- R2: A one-cycle pulse on an error input sets its flag from the next cycle. The flags sit in `lsr_o` as bit 1 overrun, bit 2 parity, bit 3 framing and bit 4 break. A set flag stays set until a line status read.
- R3: In a cycle with `lsr_rd_i` high, `lsr_o` shows the flags before clearing. From the next cycle, bits 1 to 4 of `lsr_o` and of `rx_stat_o` read zero.
- R4: An error pulse that comes in the same cycle as a line status read leaves its flag set after the read.
- R5: Bit 0 of `lsr_o` (receive request) goes high one cycle after `rx_level_i` is strictly greater than `rx_thresh_i`. It stays low when the two are equal.
- R6: Bit 0 of `lsr_o` is low in every cycle in which `rx_fifo_rd_i` is high.
- R7: A write (`wr_i` high) with `wr_data0_i` low clears the receive request in the next cycle. The request comes back the cycle after that if the level is still above the threshold. A write with `wr_data0_i` high has no effect on it.
- R8: Bit 5 of `lsr_o` is high one cycle after `tx_level_i` is less than or equal to `tx_thresh_i`, and low one cycle after it is greater.
- R9: Bit 6 of `lsr_o` equals `tx_idle_i` delayed by one cycle.
- R10: Bit 7 of `lsr_o` is always 0. `rx_stat_o` carries the receive request in bit 0 and the same four error flags as `lsr_o` in bits 1 to 4. Its bits 5 to 7 are 0.
- R11: A write leaves bits 1 to 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovr_err_i | input | 1 | Overrun error pulse |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_det_i | input | 1 | Break detected pulse |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_thresh_i | input | LVL_W | Receive FIFO threshold |
| rx_fifo_rd_i | input | 1 | Receive FIFO read in progress |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_thresh_i | input | LVL_W | Transmit FIFO threshold |
| tx_idle_i | input | 1 | Transmit state machine idle (empty or disabled) |
| lsr_rd_i | input | 1 | CPU read strobe of the line status register |
| wr_i | input | 1 | CPU write strobe of the line status register |
| wr_data0_i | input | 1 | Bit 0 of the write data |
| lsr_o | output | 8 | Line status byte |
| rx_stat_o | output | 8 | Receive status view of the shared flags |

## Verification
Two events can fall in the same cycle: a clearing read of the line status register and a new error pulse. The bench provokes this by raising `lsr_rd_i` and a parity pulse on one clock. It then expects only the parity flag to remain, with the other flags cleared. A second overlap is also provoked: a receive FIFO read that masks the request while the acknowledge path and the level comparison still run. Here the bench judges bit 0 in the masked cycles and again once the read ends.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned N_ERR   = 4;
  localparam int unsigned B_RXREQ = 0;
  localparam int unsigned B_ERR0  = 1;
  localparam int unsigned B_TXLOW = 5;
  localparam int unsigned B_TXIDL = 6;
  localparam int unsigned B_RSV   = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } err_vec_t;
endpackage

// File: rtl/lsr_err_bank.sv
module lsr_err_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set wins over clear so a racing event is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= (flag_q[g] & ~clr_i) | set_i[g];
    end

    AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !clr_i) |=> flag_o[g]); // R2
    AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[g]) |=> !flag_o[g]); // R3
    AST_ERR_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]); // R4
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lsr_rx_req.sv
module lsr_rx_req #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] thresh_i,
  input  logic         fifo_rd_i,
  input  logic         ack_i,
  output logic         req_o
);
  logic above, req_q;

  assign above = level_i > thresh_i;

  // ack drops the request for exactly one cycle; level re-evaluated after
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= above & ~ack_i;
  end

  assign req_o = req_q & ~fifo_rd_i;

  AST_RX_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !req_o); // R7
  AST_RX_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i > thresh_i && !ack_i) |=> (req_o || fifo_rd_i)); // R5
  AST_RX_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i <= thresh_i) |=> !req_o); // R5
endmodule

// File: rtl/lsr_tx_view.sv
module lsr_tx_view #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] thresh_i,
  input  logic         idle_i,
  output logic         low_o,
  output logic         idle_o
);
  logic low_q, idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      low_q  <= level_i <= thresh_i;
      idle_q <= idle_i;
    end
  end

  assign low_o  = low_q;
  assign idle_o = idle_q;

  AST_TX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i <= thresh_i) |=> low_o); // R8
  AST_TX_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i > thresh_i) |=> !low_o); // R8
  AST_TX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> idle_o); // R9
endmodule

// File: rtl/line_stat_reg.sv
module line_stat_reg
  import lsr_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovr_err_i,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic             brk_det_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_thresh_i,
  input  logic             rx_fifo_rd_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_thresh_i,
  input  logic             tx_idle_i,
  input  logic             lsr_rd_i,
  input  logic             wr_i,
  input  logic             wr_data0_i,
  output logic [7:0]       lsr_o,
  output logic [7:0]       rx_stat_o
);
  err_vec_t   err_set;
  logic [N_ERR-1:0] err_flag;
  logic       rx_req, tx_low, tx_idl, rx_ack;

  assign err_set = '{brk: brk_det_i, frm: frm_err_i, par: par_err_i, ovr: ovr_err_i};
  assign rx_ack  = wr_i & ~wr_data0_i;

  lsr_err_bank #(.N(N_ERR)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (lsr_rd_i),
    .flag_o (err_flag)
  );

  lsr_rx_req #(.W(LVL_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (rx_level_i),
    .thresh_i  (rx_thresh_i),
    .fifo_rd_i (rx_fifo_rd_i),
    .ack_i     (rx_ack),
    .req_o     (rx_req)
  );

  lsr_tx_view #(.W(LVL_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (tx_level_i),
    .thresh_i (tx_thresh_i),
    .idle_i   (tx_idle_i),
    .low_o    (tx_low),
    .idle_o   (tx_idl)
  );

  always_comb begin
    lsr_o = '0;
    lsr_o[B_RXREQ]                = rx_req;
    lsr_o[B_ERR0 +: N_ERR]        = err_flag;
    lsr_o[B_TXLOW]                = tx_low;
    lsr_o[B_TXIDL]                = tx_idl;
    lsr_o[B_RSV]                  = 1'b0;
  end

  // receive status view shares the same storage
  always_comb begin
    rx_stat_o = '0;
    rx_stat_o[0]              = rx_req;
    rx_stat_o[1 +: N_ERR]     = err_flag;
  end

  AST_WR_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !lsr_rd_i && err_set == '0) |=> $stable(lsr_o[4:1])); // R11
  AST_RX_READ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fifo_rd_i |-> !rx_stat_o[0]); // R6
endmodule

// File: tb/line_stat_reg_test.sv
`timescale 1ns/1ps
module line_stat_reg_test;
  localparam int W = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ovr_err_i = 0, par_err_i = 0, frm_err_i = 0, brk_det_i = 0;
  logic [W-1:0] rx_level_i = 0, rx_thresh_i = 4, tx_level_i = 5, tx_thresh_i = 2;
  logic rx_fifo_rd_i = 0, tx_idle_i = 0, lsr_rd_i = 0, wr_i = 0, wr_data0_i = 0;
  logic [7:0] lsr_o, rx_stat_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  line_stat_reg #(.LVL_W(W)) uut (
    .clk_i, .rst_ni, .ovr_err_i, .par_err_i, .frm_err_i, .brk_det_i,
    .rx_level_i, .rx_thresh_i, .rx_fifo_rd_i, .tx_level_i, .tx_thresh_i,
    .tx_idle_i, .lsr_rd_i, .wr_i, .wr_data0_i, .lsr_o, .rx_stat_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    #20; chk(lsr_o, 8'h00, "R1 during reset");
    chk(rx_stat_o, 8'h00, "R1 rx view during reset");
    @(negedge clk_i); rst_ni = 1'b1;
    #1; chk(lsr_o, 8'h00, "R1 after release");
    step(); chk(lsr_o, 8'h00, "R1 first cycle");
  endtask

  task automatic t_err_set();
    for (int i = 0; i < 4; i++) begin
      ovr_err_i = (i == 0); par_err_i = (i == 1); frm_err_i = (i == 2); brk_det_i = (i == 3);
      step();
      ovr_err_i = 0; par_err_i = 0; frm_err_i = 0; brk_det_i = 0;
      chk({7'b0, lsr_o[i+1]}, 8'h01, "R2 flag set");
      chk({7'b0, rx_stat_o[i+1]}, 8'h01, "R10 rx view flag");
    end
    step(); step();
    chk({4'b0, lsr_o[4:1]}, 8'h0f, "R2 sticky");
    chk(lsr_o[7], 8'h00, "R10 reserved bit");
  endtask

  task automatic t_read_clear();
    lsr_rd_i = 1;
    chk({4'b0, lsr_o[4:1]}, 8'h0f, "R3 read returns flags");
    step(); lsr_rd_i = 0;
    chk({4'b0, lsr_o[4:1]}, 8'h00, "R3 cleared lsr");
    chk({4'b0, rx_stat_o[4:1]}, 8'h00, "R3 cleared rx view");
  endtask

  task automatic t_race();
    ovr_err_i = 1; frm_err_i = 1; step(); ovr_err_i = 0; frm_err_i = 0;
    lsr_rd_i = 1; par_err_i = 1;
    step(); lsr_rd_i = 0; par_err_i = 0;
    chk({4'b0, lsr_o[4:1]}, 8'h02, "R4 racing pulse kept");
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk({4'b0, lsr_o[4:1]}, 8'h00, "R3 race cleanup");
  endtask

  task automatic t_rx_req();
    rx_level_i = 4; step(); step();
    chk({7'b0, lsr_o[0]}, 8'h00, "R5 equal stays low");
    rx_level_i = 5; step();
    chk({7'b0, lsr_o[0]}, 8'h01, "R5 above sets");
    chk({7'b0, rx_stat_o[0]}, 8'h01, "R10 rx view request");
  endtask

  task automatic t_rx_rd();
    rx_fifo_rd_i = 1; #1;
    chk({7'b0, lsr_o[0]}, 8'h00, "R6 masked same cycle");
    step();
    chk({7'b0, lsr_o[0]}, 8'h00, "R6 masked during read");
    rx_fifo_rd_i = 0; #1;
    chk({7'b0, lsr_o[0]}, 8'h01, "R6 back after read");
  endtask

  task automatic t_ack();
    frm_err_i = 1; step(); frm_err_i = 0;
    wr_i = 1; wr_data0_i = 0; step(); wr_i = 0;
    chk({7'b0, lsr_o[0]}, 8'h00, "R7 ack clears");
    chk({4'b0, lsr_o[4:1]}, 8'h04, "R11 write keeps flags");
    step();
    chk({7'b0, lsr_o[0]}, 8'h01, "R7 re-asserts");
    wr_i = 1; wr_data0_i = 1; step(); wr_i = 0;
    chk({7'b0, lsr_o[0]}, 8'h01, "R7 write one no effect");
    chk({4'b0, lsr_o[4:1]}, 8'h04, "R11 flags after second write");
    rx_level_i = 0; lsr_rd_i = 1; step(); lsr_rd_i = 0;
  endtask

  task automatic t_tx();
    chk({7'b0, lsr_o[5]}, 8'h00, "R8 above threshold");
    tx_level_i = 2; step();
    chk({7'b0, lsr_o[5]}, 8'h01, "R8 equal is low-level");
    tx_level_i = 3; step();
    chk({7'b0, lsr_o[5]}, 8'h00, "R8 one above");
    tx_idle_i = 1; step();
    chk({7'b0, lsr_o[6]}, 8'h01, "R9 idle");
    tx_idle_i = 0; step();
    chk({7'b0, lsr_o[6]}, 8'h00, "R9 busy");
    chk(lsr_o, 8'h00, "R10 full byte");
  endtask

  initial begin
    t_reset();
    t_err_set();
    t_read_clear();
    t_race();
    t_rx_req();
    t_rx_rd();
    t_ack();
    t_tx();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule